// File: doc/BRIEF.md
# Low-Speed Clock Frequency Monitor

This block watches a slow external oscillator from a faster local reference clock. It brings the monitored clock into the reference domain through a two-flop synchroniser and counts its rising edges over a fixed window of 256 reference cycles. At the end of each window the count is compared with two 8-bit thresholds. A count below the lower threshold marks the oscillator as stopped. A count below the upper threshold marks it as failing.

Measurement is switched on and off by writing a key byte. While either flag is pending, the monitor holds its counters idle. When software clears the pending flags with a write-1-to-clear, measurement resumes with a full fresh window. Each flag has its own interrupt enable, and a single registered interrupt line reports the enabled flags.

Top module: `lsfm_freq_mon`

## Requirements
- R1: After a synchronous reset, `stop_flag`, `fail_flag`, `irq` and `mon_active` are all 0.
- R2: A `key_wr` pulse with `key_byte` = 0x44 turns monitoring on. One with 0x40 turns it off. Any other key value leaves the on/off state unchanged.
- R3: The first window after enable is a full 256-cycle window. No flag changes until the second clock edge after the 256th counting cycle.
- R4: At the end of a window, `stop_flag` is set when the edge count is strictly less than `bound_cfg[7:0]`.
- R5: At the end of a window, `fail_flag` is set when the edge count is strictly less than `bound_cfg[23:16]`. A threshold of 0 never sets a flag.
- R6: While either flag is 1, `mon_active` is 0 and no window is measured.
- R7: A `clr_wr` pulse clears `stop_flag` where `clr_mask[0]` = 1 and `fail_flag` where `clr_mask[1]` = 1. A mask bit of 0 leaves its flag as it is.
- R8: After the pending flags are cleared, measurement restarts with a full 256-cycle window.
- R9: `irq` is 1 exactly when (`stop_flag` and `irq_en[0]`) or (`fail_flag` and `irq_en[1]`), registered with the flags.
- R10: A window whose 256th counting cycle coincides with the disable write is still classified.
- R11: Rising edges of `mon_clk` are counted after synchronisation. A monitored clock with a period of 2 reference cycles yields 128 edges per window, and one with a period of 8 yields about 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Monitored low-speed clock, asynchronous |
| key_wr | input | 1 | Strobe for the enable key write |
| key_byte | input | 8 | Key value: 0x44 on, 0x40 off |
| bound_cfg | input | 32 | Stop threshold in bits 7:0, fail threshold in bits 23:16 |
| clr_wr | input | 1 | Strobe for flag clear |
| clr_mask | input | 2 | Write-1-to-clear mask: bit 0 stop, bit 1 fail |
| irq_en | input | 2 | Interrupt enables: bit 0 stop, bit 1 fail |
| stop_flag | output | 1 | Oscillator judged stopped |
| fail_flag | output | 1 | Oscillator judged out of range |
| irq | output | 1 | Interrupt request |
| mon_active | output | 1 | Monitor currently measuring |

## Verification
Two events can fall in the same clock cycle: the last counting cycle of a window, and a key write that switches monitoring off. The bench drives the monitored clock stopped, enables the monitor, counts 255 cycles, and places the 0x40 write so that it lands on the 256th counting edge. The run passes when both flags still appear and `mon_active` is left low. This shows that the completed window is judged even though the disable has already taken effect.

// File: rtl/lsfm_pkg.sv
package lsfm_pkg;
  localparam logic [7:0] KEY_ON  = 8'h44;
  localparam logic [7:0] KEY_OFF = 8'h40;

  localparam int STOP_LSB = 0;
  localparam int FAIL_LSB = 16;

  typedef enum int {FLG_STOP = 0, FLG_FAIL = 1} flag_idx_e;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/lsfm_edge_sync.sv
module lsfm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], async_in};
  end

  // chain_q[STAGES-1] is the last synchronising flop, chain_q[STAGES] its history
  assign rise_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/lsfm_window.sv
module lsfm_window #(
  parameter int WIN_LEN = 256,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             edge_pulse,
  output logic             done,
  output logic [CNT_W-1:0] result
);
  localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             last_cycle;

  assign last_cycle = (win_q == WIN_LAST);

  always_comb begin
    cnt_next = cnt_q;
    if (edge_pulse && (cnt_q != CNT_MAX)) cnt_next = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      cnt_q  <= '0;
      done   <= 1'b0;
      result <= '0;
    end else if (!run) begin
      win_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_cycle;
      if (last_cycle) begin
        win_q  <= '0;
        cnt_q  <= '0;
        result <= cnt_next;
      end else begin
        win_q <= win_q + 1'b1;
        cnt_q <= cnt_next;
      end
    end
  end
endmodule

// File: rtl/lsfm_flags.sv
module lsfm_flags
  import lsfm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 done,
  input  logic [CNT_W-1:0]     result,
  input  logic [CNT_W-1:0]     stop_bd,
  input  logic [CNT_W-1:0]     fail_bd,
  input  logic                 clr_wr,
  input  logic [NUM_FLAGS-1:0] clr_mask,
  input  logic [NUM_FLAGS-1:0] irq_en,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] hit;
  logic [NUM_FLAGS-1:0] flags_d;

  always_comb begin
    hit           = '0;
    hit[FLG_STOP] = (result < stop_bd);
    hit[FLG_FAIL] = (result < fail_bd);
    flags_d = flags;
    if (clr_wr) flags_d = flags_d & ~clr_mask;
    if (done)   flags_d = flags_d | hit;   // a fresh result wins over a clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_d;
      irq   <= |(flags_d & irq_en);
    end
  end
endmodule

// File: rtl/lsfm_freq_mon.sv
module lsfm_freq_mon
  import lsfm_pkg::*;
#(
  parameter int WIN_LEN     = 256,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mon_clk,
  input  logic        key_wr,
  input  logic [7:0]  key_byte,
  input  logic [31:0] bound_cfg,
  input  logic        clr_wr,
  input  logic [1:0]  clr_mask,
  input  logic [1:0]  irq_en,
  output logic        stop_flag,
  output logic        fail_flag,
  output logic        irq,
  output logic        mon_active
);
  logic                 en_q;
  logic                 run;
  logic                 rise;
  logic                 win_done;
  logic [CNT_W-1:0]     win_result;
  logic [NUM_FLAGS-1:0] flags;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else if (key_wr) begin
      if (key_byte == KEY_ON)       en_q <= 1'b1;
      else if (key_byte == KEY_OFF) en_q <= 1'b0;
    end
  end

  assign run = en_q & ~(|flags);

  lsfm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(mon_clk), .rise_pulse(rise)
  );

  lsfm_window #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst(rst), .run(run), .edge_pulse(rise),
    .done(win_done), .result(win_result)
  );

  lsfm_flags #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst(rst), .done(win_done), .result(win_result),
    .stop_bd(bound_cfg[STOP_LSB +: CNT_W]),
    .fail_bd(bound_cfg[FAIL_LSB +: CNT_W]),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .irq_en(irq_en),
    .flags(flags), .irq(irq)
  );

  assign stop_flag  = flags[FLG_STOP];
  assign fail_flag  = flags[FLG_FAIL];
  assign mon_active = run;
endmodule

// File: rtl/lsfm_mon_chk.sv
module lsfm_mon_chk (
  input logic       clk,
  input logic       rst,
  input logic       key_wr,
  input logic [7:0] key_byte,
  input logic       clr_wr,
  input logic [1:0] clr_mask,
  input logic [1:0] irq_en,
  input logic       stop_flag,
  input logic       fail_flag,
  input logic       irq,
  input logic       mon_active,
  input logic       en_q,
  input logic       win_done
);
  // R2: unknown key values leave the enable state alone
  assert_bad_key_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (key_wr && key_byte != 8'h44 && key_byte != 8'h40) |=> $stable(en_q));

  // R3: flags only rise right after a window finished
  assert_stop_after_window_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_flag) |-> $past(win_done));
  assert_fail_after_window_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_flag) |-> $past(win_done));

  // R6: no measurement while a flag is pending
  assert_paused_on_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (stop_flag || fail_flag) |-> !mon_active);

  // R7: a clear with no competing result empties the flag
  assert_clear_fail_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_mask[1] && !win_done) |=> !fail_flag);
  assert_clear_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_mask[0] && !win_done) |=> !stop_flag);

  // R9: interrupt tracks enabled flags
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((stop_flag && $past(irq_en[0])) || (fail_flag && $past(irq_en[1]))));
endmodule

bind lsfm_freq_mon lsfm_mon_chk u_chk (
  .clk(clk), .rst(rst), .key_wr(key_wr), .key_byte(key_byte),
  .clr_wr(clr_wr), .clr_mask(clr_mask), .irq_en(irq_en),
  .stop_flag(stop_flag), .fail_flag(fail_flag), .irq(irq),
  .mon_active(mon_active), .en_q(en_q), .win_done(win_done)
);

// File: tb/lsfm_freq_mon_tb.sv
module lsfm_freq_mon_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mon_clk = 1'b0;
  logic        key_wr = 1'b0;
  logic [7:0]  key_byte = 8'h00;
  logic [31:0] bound_cfg = 32'h0;
  logic        clr_wr = 1'b0;
  logic [1:0]  clr_mask = 2'b00;
  logic [1:0]  irq_en = 2'b00;
  logic        stop_flag, fail_flag, irq, mon_active;

  int n_checks = 0;
  int n_pass   = 0;
  int mon_half = 0;

  lsfm_freq_mon u_dut (
    .clk(clk), .rst(rst), .mon_clk(mon_clk), .key_wr(key_wr), .key_byte(key_byte),
    .bound_cfg(bound_cfg), .clr_wr(clr_wr), .clr_mask(clr_mask), .irq_en(irq_en),
    .stop_flag(stop_flag), .fail_flag(fail_flag), .irq(irq), .mon_active(mon_active)
  );

  always #(CLK_P/2) clk = ~clk;

  // monitored clock: toggles every mon_half reference periods, held low when 0
  always begin
    if (mon_half == 0) begin
      mon_clk = 1'b0;
      @(posedge clk);
    end else begin
      #(mon_half*CLK_P) mon_clk = ~mon_clk;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act === exp) n_pass++;
    else $display("FAIL %s: actual %0b expected %0b", req, act, exp);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic key_write(input logic [7:0] k);
    @(negedge clk); key_wr = 1'b1; key_byte = k;
    @(negedge clk); key_wr = 1'b0;
  endtask

  task automatic clear_write(input logic [1:0] m);
    @(negedge clk); clr_wr = 1'b1; clr_mask = m;
    @(negedge clk); clr_wr = 1'b0; clr_mask = 2'b00;
  endtask

  function automatic logic [31:0] bounds(input logic [7:0] stp, input logic [7:0] fl);
    return {8'h00, fl, 8'h00, stp};
  endfunction

  task automatic t_reset;
    chk("R1 stop_flag", stop_flag, 1'b0);
    chk("R1 fail_flag", fail_flag, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 mon_active", mon_active, 1'b0);
  endtask

  task automatic t_bad_key;
    mon_half = 0; bound_cfg = bounds(8'd20, 8'd100);
    wait_cyc(10);
    key_write(8'h45);
    chk("R2 bad key keeps off", mon_active, 1'b0);
    wait_cyc(300);
    chk("R2 bad key no window", stop_flag, 1'b0);
  endtask

  task automatic t_fast;
    mon_half = 1; bound_cfg = bounds(8'd20, 8'd100);
    wait_cyc(10);
    key_write(8'h44);
    chk("R2 on key", mon_active, 1'b1);
    wait_cyc(600);
    chk("R11 fast clock no fail", fail_flag, 1'b0);
    chk("R11 fast clock no stop", stop_flag, 1'b0);
    chk("R11 still active", mon_active, 1'b1);
    key_write(8'h40);
    chk("R2 off key", mon_active, 1'b0);
  endtask

  task automatic t_slow;
    mon_half = 4; bound_cfg = bounds(8'd20, 8'd100); irq_en = 2'b10;
    wait_cyc(10);
    key_write(8'h44);
    wait_cyc(250);
    chk("R3 no early flag", fail_flag, 1'b0);
    wait_cyc(12);
    chk("R5 slow clock fails", fail_flag, 1'b1);
    chk("R4 slow clock not stopped", stop_flag, 1'b0);
    chk("R6 paused", mon_active, 1'b0);
    chk("R9 irq enabled fail", irq, 1'b1);
    wait_cyc(300);
    chk("R6 still pending", fail_flag, 1'b1);
    clear_write(2'b01);
    chk("R7 zero mask keeps fail", fail_flag, 1'b1);
    mon_half = 1;
    wait_cyc(10);
    clear_write(2'b10);
    chk("R7 fail cleared", fail_flag, 1'b0);
    chk("R8 resumed", mon_active, 1'b1);
    chk("R9 irq drops", irq, 1'b0);
    wait_cyc(300);
    chk("R8 fast window after resume", fail_flag, 1'b0);
    key_write(8'h40);
    irq_en = 2'b00;
  endtask

  task automatic t_stopped;
    mon_half = 0; bound_cfg = bounds(8'd20, 8'd100); irq_en = 2'b00;
    wait_cyc(20);
    key_write(8'h44);
    wait_cyc(262);
    chk("R4 stopped clock", stop_flag, 1'b1);
    chk("R5 stopped clock fails", fail_flag, 1'b1);
    chk("R9 masked irq", irq, 1'b0);
    clear_write(2'b11);
    wait_cyc(250);
    chk("R8 full window stop", stop_flag, 1'b0);
    chk("R8 full window fail", fail_flag, 1'b0);
    wait_cyc(12);
    chk("R8 window ends stop", stop_flag, 1'b1);
    chk("R8 window ends fail", fail_flag, 1'b1);
    key_write(8'h40);
    clear_write(2'b11);
  endtask

  task automatic t_zero_bound;
    mon_half = 0; bound_cfg = bounds(8'd0, 8'd0);
    wait_cyc(10);
    key_write(8'h44);
    wait_cyc(300);
    chk("R5 zero bound no fail", fail_flag, 1'b0);
    chk("R4 zero bound no stop", stop_flag, 1'b0);
    key_write(8'h40);
  endtask

  task automatic t_collision;
    mon_half = 0; bound_cfg = bounds(8'd20, 8'd100);
    wait_cyc(10);
    key_write(8'h44);
    wait_cyc(255);
    key_byte = 8'h40; key_wr = 1'b1;
    @(negedge clk); key_wr = 1'b0;
    wait_cyc(4);
    chk("R10 window judged stop", stop_flag, 1'b1);
    chk("R10 window judged fail", fail_flag, 1'b1);
    clear_write(2'b11);
    chk("R10 disabled after clear", mon_active, 1'b0);
  endtask

  initial begin
    #(CLK_P*200000);
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_pass, n_checks);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    t_reset();
    t_bad_key();
    t_fast();
    t_slow();
    t_stopped();
    t_zero_bound();
    t_collision();
    $display("%0d/%0d checks passed", n_pass, n_checks);
    $finish;
  end
endmodule